// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs a multi-word programming session for a serial flash. It sits behind a serial front end that has already shifted and framed each command. On every chip-select rise the front end reports the opcode, the address, up to two data bytes, how many whole bytes arrived, and whether the frame was cut off in the middle of a byte. An opening command (opcode ADh, three address bytes, two data bytes) starts a session at an even address. After that, each short frame (ADh plus two data bytes) writes the next two-byte pair. The address moves up by two each time without being resent.

Each accepted pair leaves the block as a one-cycle write request to the memory-array port. The request carries the even address, the byte for the even location and the byte for the odd location. A parameterised counter stands in for the self-timed programming delay, and frames that arrive during that delay are dropped. A ready/busy output mode can be switched on before a session. With it on, the serial data-out line reports ready or busy whenever the chip is selected during a session.

The session closes in one of two ways. The write-disable command closes it, or the block closes it by itself when the next pair would run past the top of the address space or into protected memory. Either way the block pulses a request to clear the write-enable latch.

States: `S_IDLE` (no session), `S_PROG` (a pair is being programmed, busy), `S_WAIT` (session open and ready for the next pair). Transitions: `S_IDLE→S_PROG` on a valid opening frame with write enable set and an unprotected target. `S_PROG→S_WAIT` when the busy count expires and the next pair is in range. `S_PROG→S_IDLE` when the busy count expires and the next pair is out of range or protected. `S_WAIT→S_PROG` on a valid continuation frame. `S_WAIT→S_IDLE` on write-disable.

Top module: `autoinc_word_prog`

## Requirements
- R1: A six-byte, unbroken opcode-ADh frame received while no session is open and `wel_in`=1 opens a session. In the cycle after `frm_end`, `wr_req` pulses with `wr_addr` = `frm_addr` with bit 0 cleared, `wr_lo` = first data byte and `wr_hi` = second data byte, and `sess_open` goes to 1.
- R2: After each launched write, `busy` stays high for exactly BUSY_CYC cycles, starting in the cycle of `wr_req`.
- R3: In the ready part of a session, a three-byte opcode-ADh frame writes the next pair at the previous pair address plus two. Any frame that arrives while `busy` is high has no effect.
- R4: An opening frame received with `wel_in`=0 is ignored.
- R5: An opening frame is ignored if `prot_hit` is 1 for its even target address, which is presented on `prot_addr` while idle.
- R6: A frame with the wrong byte count for its opcode (6 to open, 3 to continue, 1 for single-byte commands), or with `frm_partial`=1, is discarded.
- R7: While a session is open, only opcode ADh (continue) and 04h (write-disable) have an effect. Opcodes 70h, 80h and a six-byte ADh frame are ignored.
- R8: Opcode 70h, when no session is open, sets `rb_mode`. With `rb_mode`=1, a session open and `cs_n`=0, `so_oe` is 1 and `so_out` is 0 while busy and 1 while ready. With `cs_n`=1, `so_oe` is 0.
- R9: Opcode 04h, when not busy, closes the session and pulses `wel_clr` for one cycle. Opcode 80h, when no session is open, clears `rb_mode`.
- R10: When a busy period ends and the next pair address is protected, the session closes and `wel_clr` pulses.
- R11: When the next pair address would pass the top of the address space, the session closes and `wel_clr` pulses. There is no wrap to address zero.
- R12: After reset: `sess_open`, `busy`, `rb_mode`, `wr_req`, `wel_clr` and `so_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, active low |
| frm_end | input | 1 | One-cycle pulse: a frame ended with select rising |
| frm_op | input | 8 | Opcode of the frame |
| frm_addr | input | AW | Address carried by the frame |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| frm_nbytes | input | NBW | Count of whole bytes received, opcode included |
| frm_partial | input | 1 | Select rose inside a byte |
| wel_in | input | 1 | Write-enable latch state |
| prot_hit | input | 1 | Protection lookup result for prot_addr |
| prot_addr | output | AW | Address sent to the protection lookup |
| wr_req | output | 1 | One-cycle write request to the array |
| wr_addr | output | AW | Even address of the pair |
| wr_lo | output | 8 | Byte for the even location |
| wr_hi | output | 8 | Byte for the odd location |
| wel_clr | output | 1 | Pulse requesting the write-enable latch be cleared |
| sess_open | output | 1 | Session mode flag |
| busy | output | 1 | Programming delay in progress |
| rb_mode | output | 1 | Ready/busy reporting on data-out is enabled |
| so_oe | output | 1 | Data-out driver enable |
| so_out | output | 1 | Data-out value when enabled |

## Verification
The bench sends a continuation frame during a busy period. A sequencer that let it through would raise a second write that the scoreboard never expected. It also sends frames cut short by one byte, frames flagged partial, and mode-change commands while a session is open. A design that did not check byte counts or enforce the restricted command set would issue writes or change `rb_mode`. Sessions are run up to a protection boundary and up to the very top of the address space. A design that wrapped the address or checked only the opening target would keep the session open and never pulse `wel_clr`. The data-out line is sampled during and after busy with select low and high, which exposes an inverted polarity or a driver left on after deselect.

// File: rtl/awp_pkg.sv
package awp_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PROG = 2'd1,
        S_WAIT = 2'd2
    } awp_state_e;

    localparam logic [7:0] OP_PAIR  = 8'hAD;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RBON  = 8'h70;
    localparam logic [7:0] OP_RBOFF = 8'h80;

    localparam int NB_OPEN = 6;
    localparam int NB_CONT = 3;
    localparam int NB_CMD  = 1;
endpackage

// File: rtl/awp_frame_dec.sv
module awp_frame_dec
    import awp_pkg::*;
#(
    parameter int NBW = 4
) (
    input  logic           frm_end,
    input  logic [7:0]     frm_op,
    input  logic [NBW-1:0] frm_nbytes,
    input  logic           frm_partial,
    input  logic           in_sess,
    input  logic           ready,
    input  logic           busy,
    output logic           open_ok,
    output logic           cont_ok,
    output logic           wdis_ok,
    output logic           rbon_ok,
    output logic           rboff_ok
);
    logic whole;
    logic one_byte;

    always_comb begin
        whole    = frm_end && !frm_partial;
        one_byte = (frm_nbytes == NBW'(NB_CMD));
        open_ok  = whole && !in_sess && (frm_op == OP_PAIR) && (frm_nbytes == NBW'(NB_OPEN));
        cont_ok  = whole && ready && (frm_op == OP_PAIR) && (frm_nbytes == NBW'(NB_CONT));
        wdis_ok  = whole && !busy && (frm_op == OP_WDIS) && one_byte;
        rbon_ok  = whole && !in_sess && (frm_op == OP_RBON) && one_byte;
        rboff_ok = whole && !in_sess && (frm_op == OP_RBOFF) && one_byte;
    end
endmodule

// File: rtl/awp_addr_track.sv
module awp_addr_track #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] nxt,
    output logic          last
);
    localparam logic [AW:0] STEP = (AW+1)'(2);

    logic [AW:0] sum;

    always_comb begin
        sum  = {1'b0, cur} + STEP;
        nxt  = sum[AW-1:0];
        last = sum[AW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (adv) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/awp_busy_timer.sv
module awp_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CW-1:0] LOADV = CW'(BUSY_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = running && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LOADV;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/autoinc_word_prog.sv
module autoinc_word_prog
    import awp_pkg::*;
#(
    parameter int AW       = 24,
    parameter int NBW      = 4,
    parameter int BUSY_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           frm_end,
    input  logic [7:0]     frm_op,
    input  logic [AW-1:0]  frm_addr,
    input  logic [7:0]     frm_d0,
    input  logic [7:0]     frm_d1,
    input  logic [NBW-1:0] frm_nbytes,
    input  logic           frm_partial,
    input  logic           wel_in,
    input  logic           prot_hit,
    output logic [AW-1:0]  prot_addr,
    output logic           wr_req,
    output logic [AW-1:0]  wr_addr,
    output logic [7:0]     wr_lo,
    output logic [7:0]     wr_hi,
    output logic           wel_clr,
    output logic           sess_open,
    output logic           busy,
    output logic           rb_mode,
    output logic           so_oe,
    output logic           so_out
);
    awp_state_e state, state_nx;

    logic          open_ok, cont_ok, wdis_ok, rbon_ok, rboff_ok;
    logic          t_run, t_done;
    logic [AW-1:0] cur_addr, nxt_addr, open_addr;
    logic          at_top;
    logic          launch_open, launch_cont, launch, range_end, adv;

    assign open_addr = {frm_addr[AW-1:1], 1'b0};
    assign sess_open = (state != S_IDLE);
    assign busy      = (state == S_PROG);

    awp_frame_dec #(.NBW(NBW)) u_dec (
        .frm_end     (frm_end),
        .frm_op      (frm_op),
        .frm_nbytes  (frm_nbytes),
        .frm_partial (frm_partial),
        .in_sess     (sess_open),
        .ready       (state == S_WAIT),
        .busy        (busy),
        .open_ok     (open_ok),
        .cont_ok     (cont_ok),
        .wdis_ok     (wdis_ok),
        .rbon_ok     (rbon_ok),
        .rboff_ok    (rboff_ok)
    );

    awp_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch),
        .running (t_run),
        .done    (t_done)
    );

    awp_addr_track #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch_open),
        .load_val (open_addr),
        .adv      (adv),
        .cur      (cur_addr),
        .nxt      (nxt_addr),
        .last     (at_top)
    );

    // Protection query: opening target while idle, next pair otherwise.
    assign prot_addr = (state == S_IDLE) ? open_addr : nxt_addr;

    always_comb begin
        launch_open = (state == S_IDLE) && open_ok && wel_in && !prot_hit;
        launch_cont = (state == S_WAIT) && cont_ok && !wdis_ok;
        launch      = launch_open || launch_cont;
        range_end   = (state == S_PROG) && t_done && (at_top || prot_hit);
        adv         = (state == S_PROG) && t_done && !range_end;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (launch_open) state_nx = S_PROG;
            S_PROG: if (t_done)      state_nx = range_end ? S_IDLE : S_WAIT;
            S_WAIT: begin
                if (wdis_ok)          state_nx = S_IDLE;
                else if (launch_cont) state_nx = S_PROG;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_lo   <= '0;
            wr_hi   <= '0;
            wel_clr <= 1'b0;
            rb_mode <= 1'b0;
        end else begin
            wr_req  <= launch;
            wel_clr <= wdis_ok || range_end;
            if (launch) begin
                wr_addr <= launch_open ? open_addr : cur_addr;
                wr_lo   <= frm_d0;
                wr_hi   <= frm_d1;
            end
            if (rbon_ok)       rb_mode <= 1'b1;
            else if (rboff_ok) rb_mode <= 1'b0;
        end
    end

    // Ready/busy on data-out: 0 = busy, 1 = ready.
    always_comb begin
        so_oe  = rb_mode && sess_open && !cs_n;
        so_out = so_oe ? !t_run : 1'b0;
    end
endmodule

// File: rtl/autoinc_word_prog_chk.sv
module autoinc_word_prog_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic wr_req,
    input logic wr_addr0,
    input logic wel_clr,
    input logic sess_open,
    input logic busy,
    input logic rb_mode,
    input logic so_oe
);
    // R2: busy only exists inside a session
    a_r2_busy_in_sess: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> sess_open);

    // R2: a busy period begins together with a write request
    a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wr_req);

    // R1: pair address is even
    a_r1_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !wr_addr0);

    // R3: no write launched from a frame that arrived while busy
    a_r3_no_busy_launch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !$past(busy));

    // R8: driver released when deselected or mode off
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rb_mode) |-> !so_oe);

    // R10: every session close comes with a latch-clear pulse
    a_r10_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sess_open) |-> wel_clr);

    // R7: ready/busy mode cannot change while a session is open
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_open && $past(sess_open)) |-> $stable(rb_mode));
endmodule

bind autoinc_word_prog autoinc_word_prog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_req    (wr_req),
    .wr_addr0  (wr_addr[0]),
    .wel_clr   (wel_clr),
    .sess_open (sess_open),
    .busy      (busy),
    .rb_mode   (rb_mode),
    .so_oe     (so_oe)
);

// File: tb/autoinc_word_prog_test.sv
module autoinc_word_prog_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 24;
    localparam int NBW = 4;
    localparam int BC  = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
    logic frm_end = 1'b0, frm_partial = 1'b0, wel_in = 1'b0, prot_hit;
    logic [7:0] frm_op = '0, frm_d0 = '0, frm_d1 = '0;
    logic [AW-1:0] frm_addr = '0, prot_addr, wr_addr;
    logic [NBW-1:0] frm_nbytes = '0;
    logic wr_req, wel_clr, sess_open, busy, rb_mode, so_oe, so_out;
    logic [7:0] wr_lo, wr_hi;

    logic prot_en = 1'b0;
    logic [AW-1:0] prot_base = '0;
    int n_run = 0, n_fail = 0, wclr_cnt = 0;
    logic [AW+15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always_comb prot_hit = prot_en && (prot_addr >= prot_base);

    autoinc_word_prog #(.AW(AW), .NBW(NBW), .BUSY_CYC(BC)) uut (.*);

    always @(posedge clk) if (wel_clr) wclr_cnt <= wclr_cnt + 1;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_req) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 actual=unexpected write %0h expected=none", wr_addr);
            end else begin
                logic [AW+15:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_lo, wr_hi} !== e) begin
                    n_fail++;
                    $display("FAIL R1 actual=%0h expected=%0h", {wr_addr, wr_lo, wr_hi}, e);
                end
            end
        end
    end

    task automatic frame(input logic [7:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input int nb, input logic part);
        @(negedge clk);
        frm_op = op; frm_addr = a; frm_d0 = d0; frm_d1 = d1;
        frm_nbytes = NBW'(nb); frm_partial = part; frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0; frm_partial = 1'b0;
    endtask

    task automatic expect_wr(input logic [AW-1:0] a, input logic [7:0] lo, input logic [7:0] hi);
        exp_q.push_back({a, lo, hi});
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int n, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk({sess_open, busy, rb_mode, wr_req, wel_clr, so_oe}, 0, "R12");

        // R4 no write enable
        frame(8'hAD, 24'h000011, 8'h11, 8'h22, 6, 1'b0);
        chk(sess_open, 0, "R4");
        wel_in = 1'b1;

        // R1 open session, odd address rounded down
        expect_wr(24'h000010, 8'hA1, 8'hB2);
        frame(8'hAD, 24'h000011, 8'hA1, 8'hB2, 6, 1'b0);
        chk(sess_open, 1, "R1");
        n = 0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        chk(n, BC, "R2");
        // R3 continue, then a dropped frame while busy
        expect_wr(24'h000012, 8'hC3, 8'hD4);
        frame(8'hAD, 24'h0, 8'hC3, 8'hD4, 3, 1'b0);
        chk(busy, 1, "R2");
        frame(8'hAD, 24'h0, 8'hEE, 8'hEE, 3, 1'b0);
        wait_ready();
        chk(exp_q.size(), 0, "R3");
        // R6 truncated and partial frames
        frame(8'hAD, 24'h0, 8'h55, 8'h66, 2, 1'b0);
        chk(busy, 0, "R6");
        frame(8'hAD, 24'h0, 8'h55, 8'h66, 3, 1'b1);
        chk(busy, 0, "R6");
        // R7 restricted set inside a session
        frame(8'h70, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        chk(rb_mode, 0, "R7");
        frame(8'hAD, 24'h000400, 8'h77, 8'h88, 6, 1'b0);
        chk(busy, 0, "R7");
        // R9 write-disable closes session
        w0 = wclr_cnt;
        frame(8'h04, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        chk(sess_open, 0, "R9");
        @(negedge clk);
        chk(wclr_cnt - w0, 1, "R9");

        // R5 protected target ignored
        prot_en = 1'b1; prot_base = 24'h001000;
        frame(8'hAD, 24'h001000, 8'h01, 8'h02, 6, 1'b0);
        chk(sess_open, 0, "R5");

        // R10 stop at highest unprotected pair
        w0 = wclr_cnt;
        expect_wr(24'h000FFC, 8'h31, 8'h32);
        frame(8'hAD, 24'h000FFC, 8'h31, 8'h32, 6, 1'b0);
        wait_ready();
        chk(sess_open, 1, "R10");
        expect_wr(24'h000FFE, 8'h33, 8'h34);
        frame(8'hAD, 24'h0, 8'h33, 8'h34, 3, 1'b0);
        wait_ready();
        chk({sess_open, 8'(wclr_cnt - w0)}, {1'b0, 8'd1}, "R10");

        // R11 top of address space, no wrap
        prot_en = 1'b0;
        w0 = wclr_cnt;
        expect_wr(24'hFFFFFE, 8'h41, 8'h42);
        frame(8'hAD, 24'hFFFFFF, 8'h41, 8'h42, 6, 1'b0);
        wait_ready();
        chk({sess_open, 8'(wclr_cnt - w0)}, {1'b0, 8'd1}, "R11");

        // R8 ready/busy on data-out
        frame(8'h70, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        chk(rb_mode, 1, "R8");
        expect_wr(24'h000200, 8'h51, 8'h52);
        frame(8'hAD, 24'h000200, 8'h51, 8'h52, 6, 1'b0);
        chk(so_oe, 0, "R8");
        cs_n = 1'b0;
        @(negedge clk);
        chk({so_oe, so_out}, 2'b10, "R8");
        wait_ready();
        chk({so_oe, so_out}, 2'b11, "R8");
        cs_n = 1'b1;
        @(negedge clk);
        chk(so_oe, 0, "R8");
        frame(8'h80, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        chk(rb_mode, 1, "R7");
        frame(8'h04, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        frame(8'h80, 24'h0, 8'h0, 8'h0, 1, 1'b0);
        chk({sess_open, rb_mode}, 2'b00, "R9");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R3");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule